// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block carries a stereo pair of PCM samples between parallel words and a serial audio line. The line is timed by a bit clock and framed by a word clock. Both clocks are inputs, so another device or a local generator must supply them. Each bit clock has a receive path and a transmit path. The receive path shifts the incoming data line into a left word and a right word. The transmit path sends a left word and a right word out on the data output. Bits travel most significant first.

Five framings can be chosen. Three of them split the frame into two halves by word-clock level: left-aligned, right-aligned and the common inter-IC-sound format. The other two start a frame on a word-clock rising edge and send the two samples back to back: DSP, and TDM. TDM is DSP with the slot moved later by a programmable number of bit clocks. The data output can be released on every bit clock that carries no data, so that several devices can share one line.

The block runs on a system clock `clk`. It oversamples `bclk` and `wclk`, which must be synchronous to `clk`. Each `bclk` level must last at least three `clk` cycles. The word clock and the data input must change only on falling bit-clock edges. A bench or system that uses the block this way sees the behaviour below.

The framing control is a state machine with four states:
- IDLE: right after reset. It leaves on the first bit-clock falling edge and goes to SYNC. That edge records the current word-clock level.
- SYNC: waits for the first frame mark. A mark is a word-clock level change in the half-frame modes, or a rising edge in DSP/TDM. On a mark it enters LEFT or RIGHT.
- LEFT and RIGHT: each counts bit positions from the last mark.
  - In the half-frame modes, every level change resets the count. The new level then picks LEFT or RIGHT.
  - In DSP/TDM, a rising edge resets the count and enters LEFT. LEFT moves to RIGHT once the left slot's last bit has passed.

Top module: `asp_serial_port`

## Requirements
- R1: While reset is held and on the first cycle after it is released: `dout`, `dout_oe`, `rx_left`, `rx_right` and `frame_done` are all zero.
- R2: Left-aligned framing (`cfg_fmt` = 0; codes 5 to 7 behave the same):
  - the left sample goes out while `wclk` is high and the right sample while it is low;
  - the MSB is on the first bit clock after the level change.
- R3: Inter-IC-sound framing (`cfg_fmt` = 2):
  - the left sample goes out while `wclk` is low and the right sample while it is high;
  - the MSB is one bit clock after the level change.
- R4: Right-aligned framing (`cfg_fmt` = 1):
  - the left sample goes out while `wclk` is high, and its LSB is on the last bit clock before `wclk` falls;
  - the right sample's LSB is on the last bit clock before `wclk` rises;
  - `cfg_half_len` gives the number of bit clocks in a half-frame and must be at least the sample width.
- R5: DSP framing (`cfg_fmt` = 3):
  - a `wclk` rising edge starts the frame, and the left MSB is on the first bit clock of the frame;
  - the right sample follows with no gap;
  - `wclk` may be a one-bit pulse or a square wave, and its falling edge has no effect.
- R6: TDM framing (`cfg_fmt` = 4) is DSP framing with both samples moved later by `cfg_offset` bit clocks.
- R7: Sample width (`cfg_width`):
  - code 0 selects 16 bits, 1 selects 20, 2 selects 24 and 3 selects 32;
  - samples sit in the low bits of the parallel words;
  - received words have zero upper bits, and upper bits of transmit words are ignored.
- R8: Every mode sends and receives the MSB first.
- R9: Idle bit clocks and the data line:
  - on a bit clock with no data, `din` is ignored and `dout` is 0;
  - in that case `dout_oe` is 0 when `cfg_hiz` = 1 and 1 when `cfg_hiz` = 0;
  - on data bit clocks `dout_oe` is 1.
- R10: Clock edges:
  - `din` is sampled on a `bclk` rising edge, and the captured word appears one `clk` cycle later;
  - `dout` changes only in the second `clk` cycle after a `bclk` falling edge.
- R11: `frame_done` is a one-cycle pulse in the cycle `rx_right` takes a new right sample.
- R12: Before the first frame mark after reset, no data bit is sent or received. From the first bit-clock falling edge on, `dout_oe` equals the inverse of `cfg_hiz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 3 | Framing: 0 left-aligned, 1 right-aligned, 2 inter-IC-sound, 3 DSP, 4 TDM |
| cfg_width | input | 2 | Sample width code: 16, 20, 24, 32 bits |
| cfg_offset | input | 8 | TDM slot start in bit clocks after the frame mark |
| cfg_half_len | input | 9 | Bit clocks per half-frame, used in right-aligned framing |
| cfg_hiz | input | 1 | Release `dout` on bit clocks without data |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock / frame mark |
| din | input | 1 | Serial receive data |
| tx_left | input | 32 | Left sample to send, right-aligned |
| tx_right | input | 32 | Right sample to send, right-aligned |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| rx_left | output | 32 | Last received left sample |
| rx_right | output | 32 | Last received right sample |
| frame_done | output | 1 | Pulse when a right sample has been received |

## Verification
The sensitive meeting point is two events in adjacent bit clocks. The first is the capture of a frame's last right bit, with its `frame_done` pulse. The second is the frame mark that restarts the position count and loads the next left word into the transmitter. It is provoked in two ways:
- DSP frames that are exactly twice the sample width, sent back to back;
- right-aligned frames whose half-frame equals the sample width.

In both cases the right LSB is followed at once by the next left MSB. The bench's behavioural model predicts every received word and `frame_done` on every `clk` cycle. It also predicts `dout` and `dout_oe` at every bit-clock rising edge. A lost, doubled or shifted boundary therefore shows up as a miscompare.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [2:0] {
        FMT_LJ  = 3'd0,
        FMT_RJ  = 3'd1,
        FMT_I2S = 3'd2,
        FMT_DSP = 3'd3,
        FMT_TDM = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_LEFT,
        ST_RIGHT
    } lane_e;

    function automatic int width_of(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/asp_bclk_edge.sv
module asp_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise,
    output logic fall,
    output logic fall_d
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b1;
            fall_d <= 1'b0;
        end else begin
            bclk_q <= bclk;
            fall_d <= fall;
        end
    end

    assign rise = bclk & ~bclk_q;
    assign fall = ~bclk & bclk_q;
endmodule

// File: rtl/asp_ctrl.sv
module asp_ctrl
    import asp_pkg::*;
#(
    parameter int POS_W = 9,
    parameter int OFS_W = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             wclk,
    input  logic [2:0]       cfg_fmt,
    input  logic [CNT_W-1:0] wlen,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [POS_W-1:0] cfg_half_len,
    output lane_e            lane,
    output logic             in_win,
    output logic [CNT_W-1:0] idx
);
    localparam int CW = ((POS_W > OFS_W) ? POS_W : OFS_W) + 2;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    lane_e            lane_q, lane_n;
    logic [POS_W-1:0] pos_q, pos_n, pos_inc;
    logic             w_last, dsp, hit, left_lvl;
    logic [CW-1:0]    base, start, wl_c, pos_c, half_c;

    always_comb begin
        dsp      = (cfg_fmt == FMT_DSP) || (cfg_fmt == FMT_TDM);
        left_lvl = (cfg_fmt != FMT_I2S);
        hit      = dsp ? (wclk & ~w_last) : (wclk ^ w_last);
        pos_inc  = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
        wl_c     = CW'(wlen);
        base     = (cfg_fmt == FMT_TDM) ? CW'(cfg_offset) : '0;
    end

    // next state, applied on a bit-clock falling edge
    always_comb begin
        lane_n = lane_q;
        pos_n  = pos_q;
        unique case (lane_q)
            ST_IDLE: lane_n = ST_SYNC;
            ST_SYNC: begin
                if (hit) begin
                    pos_n  = '0;
                    lane_n = (dsp || wclk == left_lvl) ? ST_LEFT : ST_RIGHT;
                end
            end
            ST_LEFT, ST_RIGHT: begin
                if (hit) begin
                    pos_n  = '0;
                    lane_n = (dsp || wclk == left_lvl) ? ST_LEFT : ST_RIGHT;
                end else begin
                    pos_n = pos_inc;
                    if (dsp && lane_q == ST_LEFT && CW'(pos_inc) >= base + wl_c)
                        lane_n = ST_RIGHT;
                end
            end
            default: lane_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= ST_IDLE;
            pos_q  <= '0;
            w_last <= 1'b0;
        end else if (fall) begin
            lane_q <= lane_n;
            pos_q  <= pos_n;
            w_last <= wclk;
        end
    end

    // outputs: data window for the current bit position
    always_comb begin
        pos_c  = CW'(pos_q);
        half_c = CW'(cfg_half_len);
        if (dsp)
            start = (lane_q == ST_LEFT) ? base : base + wl_c;
        else if (cfg_fmt == FMT_RJ)
            start = (half_c >= wl_c) ? half_c - wl_c : '0;
        else if (cfg_fmt == FMT_I2S)
            start = CW'(1);
        else
            start = '0;
        in_win = (lane_q == ST_LEFT || lane_q == ST_RIGHT)
                 && pos_c >= start && pos_c < start + wl_c;
        idx    = CNT_W'(pos_c - start);
        lane   = lane_q;
    end
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
    parameter int SAMPLE_W = 32,
    parameter int IDX_W    = 5,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_d,
    input  logic                in_win,
    input  logic                is_left,
    input  logic [CNT_W-1:0]    idx,
    input  logic [CNT_W-1:0]    wlen,
    input  logic                cfg_hiz,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                dout,
    output logic                dout_oe
);
    logic [SAMPLE_W-1:0] word_q, src;
    logic [CNT_W-1:0]    sel;

    assign src = is_left ? tx_left : tx_right;
    assign sel = wlen - CNT_W'(1) - idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (fall_d) begin
            if (in_win) begin
                dout_oe <= 1'b1;
                if (idx == '0) begin
                    word_q <= src;
                    dout   <= src[sel[IDX_W-1:0]];
                end else begin
                    dout   <= word_q[sel[IDX_W-1:0]];
                end
            end else begin
                dout_oe <= ~cfg_hiz;
                dout    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
    parameter int SAMPLE_W = 32,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                din,
    input  logic                in_win,
    input  logic                is_left,
    input  logic [CNT_W-1:0]    idx,
    input  logic [CNT_W-1:0]    wlen,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                frame_done
);
    logic [SAMPLE_W-1:0] acc_q, acc_n;

    assign acc_n = (idx == '0) ? {{(SAMPLE_W-1){1'b0}}, din}
                               : {acc_q[SAMPLE_W-2:0], din};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            rx_left    <= '0;
            rx_right   <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (rise && in_win) begin
                acc_q <= acc_n;
                if (idx == wlen - CNT_W'(1)) begin
                    if (is_left) begin
                        rx_left <= acc_n;
                    end else begin
                        rx_right   <= acc_n;
                        frame_done <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/asp_serial_port.sv
module asp_serial_port
    import asp_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int POS_W    = 9,
    parameter int OFS_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_fmt,
    input  logic [1:0]          cfg_width,
    input  logic [OFS_W-1:0]    cfg_offset,
    input  logic [POS_W-1:0]    cfg_half_len,
    input  logic                cfg_hiz,
    input  logic                bclk,
    input  logic                wclk,
    input  logic                din,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                dout,
    output logic                dout_oe,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                frame_done
);
    localparam int IDX_W = $clog2(SAMPLE_W);
    localparam int CNT_W = IDX_W + 1;

    logic             rise, fall, fall_d, in_win, is_left;
    logic [CNT_W-1:0] idx, wlen;
    lane_e            lane;

    assign wlen    = CNT_W'(width_of(cfg_width));
    assign is_left = (lane == ST_LEFT);

    asp_bclk_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk),
        .rise(rise), .fall(fall), .fall_d(fall_d)
    );

    asp_ctrl #(.POS_W(POS_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fall(fall), .wclk(wclk),
        .cfg_fmt(cfg_fmt), .wlen(wlen), .cfg_offset(cfg_offset),
        .cfg_half_len(cfg_half_len),
        .lane(lane), .in_win(in_win), .idx(idx)
    );

    asp_tx #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall_d(fall_d), .in_win(in_win),
        .is_left(is_left), .idx(idx), .wlen(wlen), .cfg_hiz(cfg_hiz),
        .tx_left(tx_left), .tx_right(tx_right),
        .dout(dout), .dout_oe(dout_oe)
    );

    asp_rx #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .din(din),
        .in_win(in_win), .is_left(is_left), .idx(idx), .wlen(wlen),
        .rx_left(rx_left), .rx_right(rx_right), .frame_done(frame_done)
    );
endmodule

// File: rtl/asp_serial_port_chk.sv
module asp_serial_port_chk #(
    parameter int SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bclk,
    input logic                cfg_hiz,
    input logic                dout,
    input logic                dout_oe,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right,
    input logic                frame_done
);
    // R11: strobe lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11: a new right word is always flagged
    a_r11_right_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_right) |-> frame_done);

    // R10: received words change just after a bit-clock rise
    a_r10_rx_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_left) |-> ($past(bclk) && !$past(bclk, 2)));

    // R10: transmit data changes only while the bit clock is low
    a_r10_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (!$past(bclk) && !$past(bclk, 2)));

    // R9: with release disabled, the driver stays on once enabled
    a_r9_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hiz && $past(!cfg_hiz) && $past(dout_oe)) |-> dout_oe);
endmodule

bind asp_serial_port asp_serial_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .cfg_hiz(cfg_hiz),
    .dout(dout), .dout_oe(dout_oe), .rx_left(rx_left),
    .rx_right(rx_right), .frame_done(frame_done)
);

// File: tb/sim_asp_serial_port.sv
`timescale 1ns/100ps
module sim_asp_serial_port;
    localparam int PW = 9;
    localparam int OW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]    cfg_fmt = 3'd0;
    logic [1:0]    cfg_width = 2'd0;
    logic [OW-1:0] cfg_offset = '0;
    logic [PW-1:0] cfg_half_len = '0;
    logic          cfg_hiz = 1'b0;
    logic          bclk = 1'b1, wclk = 1'b0, din = 1'b0;
    logic [31:0]   tx_left = '0, tx_right = '0;
    logic          dout, dout_oe, frame_done;
    logic [31:0]   rx_left, rx_right;

    asp_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_width(cfg_width),
        .cfg_offset(cfg_offset), .cfg_half_len(cfg_half_len), .cfg_hiz(cfg_hiz),
        .bclk(bclk), .wclk(wclk), .din(din), .tx_left(tx_left), .tx_right(tx_right),
        .dout(dout), .dout_oe(dout_oe), .rx_left(rx_left), .rx_right(rx_right),
        .frame_done(frame_done)
    );

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] exp_l = '0, exp_r = '0, pend_v = '0;
    logic exp_fd = 1'b0, pend_l = 1'b0, pend_r = 1'b0;
    string tag = "R1";

    // one clk cycle: apply model updates due now, compare received side
    task automatic step();
        @(negedge clk);
        exp_fd = 1'b0;
        if (pend_l) exp_l = pend_v;
        if (pend_r) begin exp_r = pend_v; exp_fd = 1'b1; end
        pend_l = 1'b0;
        pend_r = 1'b0;
        vectors++;
        if (rx_left !== exp_l || rx_right !== exp_r || frame_done !== exp_fd) begin
            miscompares++;
            $display("FAIL %s R7 R8 R10 R11 rx_left=%h rx_right=%h frame_done=%b expected %h %h %b",
                     tag, rx_left, rx_right, frame_done, exp_l, exp_r, exp_fd);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk = 1'b1; wclk = 1'b0; din = 1'b0;
        exp_l = '0; exp_r = '0; exp_fd = 1'b0; pend_l = 1'b0; pend_r = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (dout !== 1'b0 || dout_oe !== 1'b0 || rx_left !== '0 || rx_right !== '0
            || frame_done !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset state dout=%b oe=%b rxl=%h rxr=%h fd=%b expected all zero",
                     dout, dout_oe, rx_left, rx_right, frame_done);
        end
    endtask

    // one bit clock: low 3 clk, high 3 clk; dout judged just before the rise
    task automatic period(input logic w, input logic d, input logic ed, input logic eo,
                          input logic cl, input logic cr, input logic [31:0] v);
        step();
        bclk = 1'b0; wclk = w; din = d;
        step();
        step();
        step();
        vectors++;
        if (dout !== ed || dout_oe !== eo) begin
            miscompares++;
            $display("FAIL %s R8 R9 R12 dout=%b oe=%b expected %b %b", tag, dout, dout_oe, ed, eo);
        end
        bclk = 1'b1;
        pend_l = cl; pend_r = cr; pend_v = v;
        step();
        step();
    endtask

    task automatic run(input string req, input logic [2:0] fmt, input logic [1:0] wc,
                       input int hl, input int ofs, input logic hiz, input logic sq,
                       input int frames);
        int W;
        logic [31:0] mask;
        logic dspm, lvl;
        cfg_fmt = fmt; cfg_width = wc; cfg_half_len = PW'(hl);
        cfg_offset = OW'(ofs); cfg_hiz = hiz;
        do_reset();
        W = (wc == 2'd0) ? 16 : (wc == 2'd1) ? 20 : (wc == 2'd2) ? 24 : 32;
        mask = (W == 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
        dspm = (fmt == 3'd3) || (fmt == 3'd4);
        lvl  = (fmt != 3'd2);
        tag = "R12";
        repeat (2) period(dspm ? 1'b0 : ~lvl, 1'b1, 1'b0, ~hiz, 1'b0, 1'b0, 32'h0);
        tag = req;
        for (int f = 0; f < frames; f++) begin
            logic [31:0] tl, tr, rl, rr;
            tl = $urandom; tr = $urandom; rl = $urandom; rr = $urandom;
            tx_left = tl; tx_right = tr;
            for (int p = 0; p < 2 * hl; p++) begin
                int k;
                logic lf, w;
                logic [31:0] ts, rs;
                k = -1; lf = 1'b0;
                if (dspm) begin
                    int o;
                    o = (fmt == 3'd4) ? ofs : 0;
                    if (p >= o && p < o + W) begin k = p - o; lf = 1'b1; end
                    else if (p >= o + W && p < o + 2 * W) k = p - o - W;
                    w = sq ? (p < hl) : (p == 0);
                end else begin
                    int q, st;
                    lf = (p < hl);
                    q  = p % hl;
                    st = (fmt == 3'd1) ? hl - W : (fmt == 3'd2) ? 1 : 0;
                    if (q >= st && q < st + W) k = q - st;
                    w = lf ? lvl : ~lvl;
                end
                ts = lf ? tl : tr;
                rs = lf ? rl : rr;
                if (k >= 0)
                    period(w, rs[W-1-k], ts[W-1-k], 1'b1, lf && (k == W - 1),
                           !lf && (k == W - 1), rs & mask);
                else
                    period(w, ~p[0], 1'b0, ~hiz, 1'b0, 1'b0, 32'h0);
            end
        end
        repeat (4) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        run("R2", 3'd0, 2'd0, 16, 0, 1'b0, 1'b0, 3);   // left-aligned, 16 bit, tight halves
        run("R2", 3'd0, 2'd2, 32, 0, 1'b1, 1'b0, 3);   // 24 bit, released idle bits
        run("R2", 3'd6, 2'd1, 24, 0, 1'b1, 1'b0, 2);   // reserved code acts as left-aligned
        run("R3", 3'd2, 2'd1, 32, 0, 1'b0, 1'b0, 3);   // inter-IC-sound, 20 bit
        run("R3", 3'd2, 2'd3, 40, 0, 1'b1, 1'b0, 3);   // 32 bit
        run("R4", 3'd1, 2'd0, 24, 0, 1'b1, 1'b0, 3);   // right-aligned with slack
        run("R4", 3'd1, 2'd2, 24, 0, 1'b0, 1'b0, 3);   // half equals width: back to back
        run("R5", 3'd3, 2'd0, 16, 0, 1'b0, 1'b0, 3);   // DSP pulse, frame of exactly 2W
        run("R5", 3'd3, 2'd3, 40, 0, 1'b1, 1'b1, 3);   // DSP square word clock
        run("R6", 3'd4, 2'd1, 32, 5, 1'b1, 1'b0, 3);   // TDM slot at 5
        run("R6", 3'd4, 2'd0, 48, 40, 1'b1, 1'b1, 3);  // TDM slot across the square edge
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule